// File: doc/BRIEF.md
# Twelve-Bit Accumulator Machine Sequencer

This block is the control sequencer and datapath of a small word-addressed computer. Words are 12 bits wide and memory holds 4096 of them. The block runs six memory-reference operations: AND, two's-complement add, increment-and-skip-if-zero, deposit-and-clear, jump-to-subroutine and jump. Its state is a program counter, a memory buffer, an opcode register, an effective-address register, an interrupt-enable flag and a 13-bit register that joins a one-bit link to the 12-bit accumulator.

The block reaches a single-port memory through a request/valid handshake. It raises a request with an address, and for stores also a write-enable and data. It holds all of these steady until the memory returns a one-cycle valid pulse. Read data is taken only in the cycle that pulse is high. An interrupt request line is tested after each instruction completes. A one-cycle enable pulse arms the interrupt flag.

Top module: `acc12_cpu`

## Requirements
- R1: While reset is low the program counter, link-accumulator and interrupt flag are all zero. The first request after reset is a read of address 0.
- R2: Each instruction starts by reading the word at the program counter. The counter then advances by one modulo 4096, so a word fetched at 4095 is followed by a fetch at 0.
- R3: The opcode is bits 11:9. Bit 8 set means the word read at the direct address becomes the effective address. Bit 7 set means the page is the top 5 bits of (PC−1); bit 7 clear means page zero. Bits 6:0 are the offset within the page.
- R4: Opcode 0 ANDs the memory operand into the low 12 bits and leaves the link alone.
- R5: Opcode 1 adds the operand into the whole 13-bit link-accumulator, so a carry out of bit 11 toggles the link. The link changes only in the cycle an add operand arrives.
- R6: Opcode 2 writes operand+1 back to the effective address. When that 12-bit sum is zero, the next instruction is skipped.
- R7: Opcode 3 stores the accumulator at the effective address and then clears the accumulator. The link is unchanged.
- R8: Opcode 4 stores the program counter (the address after the call) at the effective address and continues at effective address + 1.
- R9: Opcode 5 continues at the effective address.
- R10: Opcodes 6 and 7 change no state other than the program counter step, and they issue no memory write. Only opcodes 2, 3 and 4 and interrupt entry ever write memory.
- R11: When an instruction completes with the interrupt flag set and the request line high, the program counter is stored at address 0. Execution then resumes by fetching from address 1, and the interrupt flag is cleared.
- R12: The request signal, address, write-enable and write data stay unchanged from the cycle a request is raised until the cycle valid is seen.
- R13: A one-cycle pulse on the enable input sets the interrupt flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq | input | 1 | Interrupt request level |
| ien_set | input | 1 | Pulse that sets the interrupt flag |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 12 | Word address |
| mem_wdata | output | 12 | Write data |
| mem_rdata | input | 12 | Read data, taken when valid is high |
| mem_valid | input | 1 | One-cycle completion pulse from memory |
| pc_o | output | 12 | Program counter |
| lac_o | output | 13 | Link (bit 12) and accumulator |
| ien_o | output | 1 | Interrupt flag |

## Verification
Every result is tied to the memory handshake rather than to a fixed cycle count. The bench memory returns valid between one and four cycles after a request, depending on the low address bits, so each instruction takes a different number of cycles. Stores are therefore checked at the falling edge inside the valid cycle, where address and data must still be held, and they are compared in order against a queue of expected stores. Register results are sampled only after the program has settled into a self-jump loop. The fetch address that follows interrupt entry is compared in the first read-valid cycle after the vector store.

// File: rtl/acc12_cpu.sv
module acc12_cpu #(
  parameter int W    = 12,
  parameter int OFFW = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         irq,
  input  logic         ien_set,
  output logic         mem_req,
  output logic         mem_we,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  input  logic [W-1:0] mem_rdata,
  input  logic         mem_valid,
  output logic [W-1:0] pc_o,
  output logic [W:0]   lac_o,
  output logic         ien_o
);
  localparam int OPL  = W - 3;
  localparam int IBIT = OFFW + 1;

  typedef enum logic [2:0] {
    S_FETCH, S_DECODE, S_IND, S_DISP, S_OPRD, S_WR, S_IRQ
  } st_t;

  st_t          st, fin_st;
  logic [W-1:0] pc, mb, ea;
  logic [2:0]   op;
  logic [W:0]   lac;
  logic         ien;

  wire [W-1:0] pc_prev = pc - W'(1);
  wire [W-1:0] rd_inc  = mem_rdata + W'(1);
  wire [W-1:0] ea_dir  = mb[OFFW] ? {pc_prev[W-1:OFFW], mb[OFFW-1:0]}
                                  : {{(W-OFFW){1'b0}}, mb[OFFW-1:0]};

  assign fin_st    = (ien && irq) ? S_IRQ : S_FETCH;
  assign mem_req   = (st == S_FETCH) || (st == S_IND) || (st == S_OPRD) ||
                     (st == S_WR) || (st == S_IRQ);
  assign mem_we    = (st == S_WR) || (st == S_IRQ);
  assign mem_addr  = (st == S_FETCH) ? pc : (st == S_IRQ) ? '0 : ea;
  assign mem_wdata = (st == S_IRQ) ? pc : mb;
  assign pc_o      = pc;
  assign lac_o     = lac;
  assign ien_o     = ien;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_FETCH;
      pc  <= '0;
      mb  <= '0;
      ea  <= '0;
      op  <= '0;
      lac <= '0;
      ien <= 1'b0;
    end else begin
      case (st)
        S_FETCH: if (mem_valid) begin
          mb <= mem_rdata;
          op <= mem_rdata[W-1:OPL];
          pc <= pc + W'(1);
          st <= S_DECODE;
        end
        S_DECODE: begin
          ea <= ea_dir;
          if (op[2] && op[1]) st <= fin_st;
          else if (mb[IBIT])  st <= S_IND;
          else                st <= S_DISP;
        end
        S_IND: if (mem_valid) begin
          ea <= mem_rdata;
          st <= S_DISP;
        end
        S_DISP: begin
          case (op)
            3'd3: begin
              mb         <= lac[W-1:0];
              lac[W-1:0] <= '0;
              st         <= S_WR;
            end
            3'd4: begin
              mb <= pc;
              pc <= ea + W'(1);
              st <= S_WR;
            end
            3'd5: begin
              pc <= ea;
              st <= fin_st;
            end
            default: st <= S_OPRD;
          endcase
        end
        S_OPRD: if (mem_valid) begin
          case (op)
            3'd0: begin
              lac[W-1:0] <= lac[W-1:0] & mem_rdata;
              st         <= fin_st;
            end
            3'd1: begin
              lac <= lac + {1'b0, mem_rdata};
              st  <= fin_st;
            end
            default: begin
              mb <= rd_inc;
              if (rd_inc == '0) pc <= pc + W'(1);
              st <= S_WR;
            end
          endcase
        end
        S_WR: if (mem_valid) st <= fin_st;
        S_IRQ: if (mem_valid) begin
          pc <= W'(1);
          st <= S_FETCH;
        end
        default: st <= S_FETCH;
      endcase

      if (st == S_IRQ && mem_valid) ien <= 1'b0;
      else if (ien_set)             ien <= 1'b1;
    end
  end
endmodule

// File: rtl/acc12_cpu_chk.sv
module acc12_cpu_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic         mem_req,
  input logic         mem_we,
  input logic         mem_valid,
  input logic [W-1:0] mem_addr,
  input logic [W-1:0] mem_wdata,
  input logic [W-1:0] pc_o,
  input logic [W:0]   lac_o,
  input logic         ien_o
);
  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (pc_o == '0 && lac_o == '0 && !ien_o));

  assert_we_with_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req);

  assert_req_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr) &&
                                 $stable(mem_we) && $stable(mem_wdata)));

  assert_link_on_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lac_o[W]) |-> $past(mem_valid));

  assert_irq_vector_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ien_o) |-> (pc_o == W'(1)));
endmodule

bind acc12_cpu acc12_cpu_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .pc_o(pc_o), .lac_o(lac_o), .ien_o(ien_o)
);

// File: tb/acc12_cpu_tb_top.sv
`timescale 1ns/1ps
module acc12_cpu_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, irq = 1'b0, ien_set = 1'b0;
  always #2.5 clk = ~clk;

  logic        mem_req, mem_we, ien_o;
  logic [11:0] mem_addr, mem_wdata, pc_o;
  logic [12:0] lac_o;
  logic        mvalid = 1'b0;
  logic [11:0] mrdata = '0;
  logic [1:0]  cnt = '0;
  logic [11:0] mem [0:4095];

  acc12_cpu dut_i (
    .clk(clk), .rst_n(rst_n), .irq(irq), .ien_set(ien_set),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mrdata), .mem_valid(mvalid),
    .pc_o(pc_o), .lac_o(lac_o), .ien_o(ien_o)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      mvalid <= 1'b0;
      cnt    <= '0;
    end else if (mvalid) mvalid <= 1'b0;
    else if (mem_req) begin
      if (cnt == mem_addr[1:0]) begin
        mvalid <= 1'b1;
        mrdata <= mem[mem_addr];
        if (mem_we) mem[mem_addr] <= mem_wdata;
        cnt <= '0;
      end else cnt <= cnt + 2'd1;
    end
  end

  int checks = 0, errors = 0, hs_viol = 0;
  bit done = 1'b0, int_watch = 1'b0, fetch_watch = 1'b0;
  logic [23:0] expq[$];
  string       tagq[$];

  task automatic chk(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic expect_wr(input logic [11:0] a, input logic [11:0] d, input string tag);
    expq.push_back({a, d});
    tagq.push_back(tag);
  endtask

  logic        prev_pend = 1'b0;
  logic [24:0] prev_req = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_pend && !(mem_req && {mem_we, mem_addr, mem_wdata} == prev_req)) hs_viol++;
      prev_pend = mem_req && !mvalid;
      prev_req  = {mem_we, mem_addr, mem_wdata};
      if (mem_req && mvalid) begin
        if (mem_we) begin
          if (expq.size() == 0)
            chk(1'b0, "R10 unexpected store", {mem_addr, mem_wdata}, 24'h0);
          else begin
            logic [23:0] e;
            string t;
            e = expq.pop_front();
            t = tagq.pop_front();
            chk({mem_addr, mem_wdata} == e, t, {mem_addr, mem_wdata}, e);
          end
          if (int_watch && mem_addr == 12'd0) begin
            int_watch   = 1'b0;
            fetch_watch = 1'b1;
          end
        end else if (fetch_watch) begin
          chk(mem_addr == 12'd1, "R11 fetch after vector", {12'h0, mem_addr}, 24'd1);
          fetch_watch = 1'b0;
        end
      end
    end else prev_pend = 1'b0;
  end

  task automatic clear_mem();
    for (int i = 0; i < 4096; i++) mem[i] = 12'h000;
  endtask

  task automatic load_one();
    clear_mem();
    mem[0]   = 12'hA10;
    mem[16]  = 12'h241; mem[17] = 12'h242; mem[18] = 12'h345; mem[19] = 12'h040;
    mem[20]  = 12'h644; mem[21] = 12'h443; mem[22] = 12'h443; mem[23] = 12'h242;
    mem[24]  = 12'hC00; mem[25] = 12'hE00; mem[26] = 12'h850; mem[27] = 12'hB47;
    mem[64]  = 12'h0F0; mem[65] = 12'hFFF; mem[66] = 12'h001; mem[67] = 12'hFFE;
    mem[69]  = 12'h046; mem[70] = 12'h123; mem[71] = 12'h200;
    mem[81]  = 12'h242; mem[82] = 12'hB50;
    mem[512] = 12'h285; mem[513] = 12'h686; mem[514] = 12'hA84;
    mem[516] = 12'hA84; mem[517] = 12'h010;
  endtask

  task automatic load_two();
    clear_mem();
    mem[0]    = 12'hB0A; mem[1] = 12'hA02; mem[2] = 12'hA02;
    mem[10]   = 12'hFFF; mem[11] = 12'h005;
    mem[4095] = 12'h20B;
  endtask

  initial begin
    load_one();
    repeat (4) @(negedge clk);
    chk(pc_o == 12'd0, "R1 pc in reset", {12'h0, pc_o}, 24'h0);
    chk(lac_o == 13'd0, "R1 lac in reset", {11'h0, lac_o}, 24'h0);
    chk(ien_o == 1'b0, "R1 ien in reset", {23'h0, ien_o}, 24'h0);
    expect_wr(12'd68,  12'h020, "R4 and R7 store after AND");
    expect_wr(12'd67,  12'hFFF, "R6 increment no skip");
    expect_wr(12'd67,  12'h000, "R6 increment wraps to zero");
    expect_wr(12'd80,  12'h01B, "R8 return address");
    expect_wr(12'd518, 12'h011, "R3 current page and R6 skip");
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_req && !mem_we && mem_addr == 12'd0, "R1 first fetch",
        {10'h0, mem_req, mem_we, mem_addr}, {10'h0, 2'b10, 12'h0});
    while (!(expq.size() == 0 && pc_o == 12'd516)) @(negedge clk);
    repeat (40) @(negedge clk);
    chk(lac_o == 13'h1000, "R5 link carry kept", {11'h0, lac_o}, 24'h1000);
    chk(pc_o == 12'd516 || pc_o == 12'd517, "R9 jump loop", {12'h0, pc_o}, 24'd516);

    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    load_two();
    expect_wr(12'd12, 12'h005, "R2 fetch wraps to 0");
    rst_n = 1'b1;
    while (pc_o != 12'hFFF) @(negedge clk);
    mem[0] = 12'h60C;
    while (expq.size() != 0) @(negedge clk);
    repeat (30) @(negedge clk);
    chk(lac_o == 13'h0000, "R7 accumulator cleared", {11'h0, lac_o}, 24'h0);
    @(negedge clk); ien_set = 1'b1;
    @(negedge clk); ien_set = 1'b0;
    chk(ien_o == 1'b1, "R13 enable pulse", {23'h0, ien_o}, 24'h1);
    expect_wr(12'd0, 12'd2, "R11 vector store");
    int_watch = 1'b1;
    irq = 1'b1;
    while (expq.size() != 0 || int_watch || fetch_watch) @(negedge clk);
    repeat (60) @(negedge clk);
    chk(ien_o == 1'b0, "R11 enable cleared", {23'h0, ien_o}, 24'h0);
    irq = 1'b0;
    chk(hs_viol == 0, "R12 request held", hs_viol[23:0], 24'h0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule